// File: doc/BRIEF.md
# Conversion Hold, Trigger and Data-Valid Flag Controller

This block sits beside a dual-slope converter's sequencer and decides when conversions run and when their results may reach the outside. Four active-low contact closures drive it: an immediate hold, a hold that takes effect once the running conversion ends, a single-shot trigger, and a flag clear. From these it starts conversions, times the integration window and the count window, and latches each finished result into the register that feeds both the display and the parallel BCD output.

Every finished and stored result raises a data-valid flag for a fixed period. The stored value never changes while that flag is high. Each of the eight 4-bit groups of the parallel output is released only while its own active-low enable is closed. All timing is given in milliseconds and scaled by a clock-cycles-per-millisecond parameter. Every contact input is synchronised with two flops and must stay stable for a debounce period before the block acts on it.

Top module: `conv_hold_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `flag` is 0, `flag_n` is 1, `disp_data` and `bcd_out` are all zero and `conv_start` is 0. With the end-of-conversion hold open, the first conversion starts within a few cycles of reset release.
- R2: While the end-of-conversion hold is open, conversions run back to back. `conv_start` pulses for one cycle at the start of each one, and consecutive pulses are exactly CONV_MS milliseconds apart.
- R3: `integ_win` rises DLY_MS (100 ms) after a conversion start and stays high for WIN_MS (200 ms). This applies in free-running mode and to triggered conversions.
- R4: At the end of each conversion, `conv_data` is stored into `disp_data`. `flag` then goes high for exactly FLAG_MS (300 ms), and the stored result does not change while `flag` is high.
- R5: While the immediate hold (`hold_n` low) is closed, conversions keep running. `disp_data` keeps its last value and `flag` does not rise.
- R6: When the end-of-conversion hold (`hold_end_n` low) closes during a conversion, that conversion completes and its result is stored. After that, no further conversion starts.
- R7: While the end-of-conversion hold is closed and no conversion runs, the release (low-to-high) of a debounced `trig_n` closure starts exactly one conversion. The closing edge starts nothing.
- R8: A trigger released while a conversion is running has no effect: no extra conversion follows.
- R9: When both holds are closed, a trigger still starts a conversion. The immediate hold takes priority: `disp_data` stays unchanged and `flag` does not rise.
- R10: While `flag_rst_n` is closed (low), `flag` is 0 and `flag_n` is 1. After the clear opens again, `flag` stays 0 until the next stored result.
- R11: Bits [4i+3:4i] of `bcd_out` carry nibble i of the stored result while `strobe_n[i]` is low, and read 0000 while it is high. `disp_data` does not depend on the strobes.
- R12: `count_win_n` is low only while a conversion is past the end of its integration window and `deint_busy` is high. Otherwise it is high.
- R13: A contact change shorter than DEB_MS milliseconds after synchronisation is ignored. For example, a two-cycle trigger pulse starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_n | input | 1 | Immediate hold closure, active low |
| hold_end_n | input | 1 | Hold-at-end-of-conversion closure, active low |
| trig_n | input | 1 | Single-shot trigger closure, acts on release |
| flag_rst_n | input | 1 | Flag clear closure, active low |
| strobe_n | input | NIB | Per-group output enables, low releases the group |
| deint_busy | input | 1 | High while the converter de-integrates and counts |
| conv_data | input | 4*NIB | BCD result presented by the converter |
| conv_start | output | 1 | One-cycle pulse at the start of a conversion |
| integ_win | output | 1 | High during the input integration window |
| count_win_n | output | 1 | Low during the count interval |
| flag | output | 1 | Data-valid flag, high for FLAG_MS after a store |
| flag_n | output | 1 | Complement of `flag` |
| disp_data | output | 4*NIB | Stored result for the display |
| bcd_out | output | 4*NIB | Stored result gated per 4-bit group |

## Verification
The in-RTL properties check on every cycle that:
- a trigger from idle always yields a start on the next cycle;
- a trigger during a running conversion never adds one;
- a conversion ending under the end-of-conversion hold leaves the sequencer idle;
- the stored result stays fixed while the flag is high and while the immediate hold is closed;
- a closed flag clear always forces the flag low.

Only the bench's scenarios can show the following, because they depend on sequences of contact activity:
- the millisecond-scale placement of the integration window and the flag width;
- the exact one-conversion count after a release edge;
- debounce rejection of a short glitch;
- the per-group strobe patterns;
- the priority of the immediate hold over a triggered conversion.

// File: rtl/cvh_pkg.sv
package cvh_pkg;
   // Debounced contact closures, active high once filtered.
   typedef struct packed {
      logic hold;
      logic hold_end;
      logic trig;
      logic frst;
   } ctl_t;

   localparam int N_CTL = 4;
endpackage

// File: rtl/cvh_debounce.sv
module cvh_debounce #(
   parameter int DEB_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_n,
   output logic closed,
   output logic released
);
   localparam int DW = (DEB_CYC < 2) ? 1 : $clog2(DEB_CYC + 1);
   localparam logic [DW-1:0] LAST = DW'(DEB_CYC - 1);

   logic          s1, s2;
   logic [DW-1:0] cnt;
   logic          now_closed;

   assign now_closed = ~s2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1       <= 1'b1;
         s2       <= 1'b1;
         closed   <= 1'b0;
         cnt      <= '0;
         released <= 1'b0;
      end else begin
         s1       <= raw_n;
         s2       <= s1;
         released <= 1'b0;
         if (now_closed == closed) begin
            cnt <= '0;
         end else if (cnt == LAST) begin
            closed   <= now_closed;
            cnt      <= '0;
            released <= closed;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   // R13: a change of the filtered level needs a full stable period first
   AST_DEB_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (closed != $past(closed)) |-> (now_closed == closed)) else $error("debounce"); // R13
endmodule

// File: rtl/cvh_conv_timer.sv
module cvh_conv_timer #(
   parameter int CONV_CYC = 2000,
   parameter int DLY_CYC  = 400,
   parameter int WIN_CYC  = 800
) (
   input  logic clk,
   input  logic rst_n,
   input  logic free_run,
   input  logic trig_rel,
   input  logic deint_busy,
   output logic conv_start,
   output logic conv_end,
   output logic integ_win,
   output logic count_win_n
);
   localparam int CW = $clog2(CONV_CYC);
   localparam logic [CW-1:0] LAST    = CW'(CONV_CYC - 1);
   localparam logic [CW-1:0] WIN_LO  = CW'(DLY_CYC);
   localparam logic [CW-1:0] WIN_HI  = CW'(DLY_CYC + WIN_CYC);

   logic          busy;
   logic [CW-1:0] cnt;

   assign conv_start  = busy && (cnt == '0);
   assign conv_end    = busy && (cnt == LAST);
   assign integ_win   = busy && (cnt >= WIN_LO) && (cnt < WIN_HI);
   assign count_win_n = ~(busy && (cnt >= WIN_HI) && deint_busy);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (busy) begin
         if (cnt == LAST) begin
            cnt  <= '0;
            busy <= free_run;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end else if (free_run || trig_rel) begin
         busy <= 1'b1;
         cnt  <= '0;
      end
   end

   AST_TRIG_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && trig_rel) |=> conv_start) else $error("trig start"); // R7
   AST_TRIG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !conv_end && trig_rel) |=> !conv_start) else $error("trig busy"); // R8
   AST_HOLD_END_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_end && !free_run) |=> !busy) else $error("hold end"); // R6
   AST_FREE_RUN_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_end && free_run) |=> conv_start) else $error("free run"); // R2
endmodule

// File: rtl/cvh_result_out.sv
module cvh_result_out #(
   parameter int NIB      = 8,
   parameter int FLAG_CYC = 1200
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             conv_end,
   input  logic             hold_act,
   input  logic             frst_act,
   input  logic [4*NIB-1:0] conv_data,
   input  logic [NIB-1:0]   strobe_n,
   output logic             flag,
   output logic             flag_n,
   output logic [4*NIB-1:0] disp_data,
   output logic [4*NIB-1:0] bcd_out
);
   localparam int FW = $clog2(FLAG_CYC + 1);
   localparam logic [FW-1:0] FLAST = FW'(FLAG_CYC - 1);

   logic [FW-1:0] fcnt;
   logic          store;

   assign store  = conv_end && !hold_act;
   assign flag_n = ~flag;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     disp_data <= '0;
      else if (store) disp_data <= conv_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b0;
         fcnt <= '0;
      end else if (frst_act) begin
         flag <= 1'b0;
         fcnt <= '0;
      end else if (store) begin
         flag <= 1'b1;
         fcnt <= '0;
      end else if (flag) begin
         if (fcnt == FLAST) flag <= 1'b0;
         else               fcnt <= fcnt + 1'b1;
      end
   end

   for (genvar g = 0; g < NIB; g++) begin : g_grp
      assign bcd_out[4*g +: 4] = strobe_n[g] ? 4'b0000 : disp_data[4*g +: 4];
   end

   AST_FLAG_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && $past(flag)) |-> $stable(disp_data)) else $error("flag data"); // R4
   AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(hold_act) |-> $stable(disp_data)) else $error("hold"); // R5
   AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $past(frst_act) |-> !flag) else $error("flag clear"); // R10
endmodule

// File: rtl/conv_hold_ctrl.sv
module conv_hold_ctrl
   import cvh_pkg::*;
#(
   parameter int CYC_PER_MS = 50000,
   parameter int DEB_MS     = 1,
   parameter int CONV_MS    = 500,
   parameter int DLY_MS     = 100,
   parameter int WIN_MS     = 200,
   parameter int FLAG_MS    = 300,
   parameter int NIB        = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold_n,
   input  logic             hold_end_n,
   input  logic             trig_n,
   input  logic             flag_rst_n,
   input  logic [NIB-1:0]   strobe_n,
   input  logic             deint_busy,
   input  logic [4*NIB-1:0] conv_data,
   output logic             conv_start,
   output logic             integ_win,
   output logic             count_win_n,
   output logic             flag,
   output logic             flag_n,
   output logic [4*NIB-1:0] disp_data,
   output logic [4*NIB-1:0] bcd_out
);
   localparam int DEB_CYC  = CYC_PER_MS * DEB_MS;
   localparam int CONV_CYC = CYC_PER_MS * CONV_MS;
   localparam int DLY_CYC  = CYC_PER_MS * DLY_MS;
   localparam int WIN_CYC  = CYC_PER_MS * WIN_MS;
   localparam int FLAG_CYC = CYC_PER_MS * FLAG_MS;

   if (FLAG_MS >= CONV_MS) begin : g_bad_flag
      $error("flag period must be shorter than a conversion");
   end
   if (DLY_MS + WIN_MS >= CONV_MS) begin : g_bad_win
      $error("integration window must end inside the conversion");
   end
   if (DEB_CYC < 1 || NIB < 1) begin : g_bad_basic
      $error("debounce period and group count must be positive");
   end

   logic [N_CTL-1:0] raw_n;
   logic [N_CTL-1:0] closed;
   logic [N_CTL-1:0] rel;
   ctl_t             act;
   logic             conv_end;

   assign raw_n = {hold_n, hold_end_n, trig_n, flag_rst_n};
   assign act   = ctl_t'(closed);

   for (genvar i = 0; i < N_CTL; i++) begin : g_deb
      cvh_debounce #(.DEB_CYC(DEB_CYC)) u_deb (
         .clk      (clk),
         .rst_n    (rst_n),
         .raw_n    (raw_n[i]),
         .closed   (closed[i]),
         .released (rel[i])
      );
   end

   cvh_conv_timer #(
      .CONV_CYC (CONV_CYC),
      .DLY_CYC  (DLY_CYC),
      .WIN_CYC  (WIN_CYC)
   ) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .free_run    (!act.hold_end),
      .trig_rel    (rel[1]),
      .deint_busy  (deint_busy),
      .conv_start  (conv_start),
      .conv_end    (conv_end),
      .integ_win   (integ_win),
      .count_win_n (count_win_n)
   );

   cvh_result_out #(
      .NIB      (NIB),
      .FLAG_CYC (FLAG_CYC)
   ) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .conv_end  (conv_end),
      .hold_act  (act.hold),
      .frst_act  (act.frst),
      .conv_data (conv_data),
      .strobe_n  (strobe_n),
      .flag      (flag),
      .flag_n    (flag_n),
      .disp_data (disp_data),
      .bcd_out   (bcd_out)
   );

   AST_WIN_IN_CONV: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(integ_win) |-> !conv_start) else $error("window"); // R3
endmodule

// File: tb/tb_conv_hold_ctrl.sv
`timescale 1ns/1ps
module tb_conv_hold_ctrl;
   localparam int CPM  = 4;
   localparam int CONV = 500 * CPM;
   localparam int DLY  = 100 * CPM;
   localparam int WIN  = 200 * CPM;
   localparam int FLG  = 300 * CPM;
   localparam int NV   = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hold_n = 1'b1, hold_end_n = 1'b1, trig_n = 1'b1, flag_rst_n = 1'b1;
   logic [7:0]  strobe_n = 8'h00;
   logic        deint_busy = 1'b0;
   logic [31:0] conv_data = 32'h0;
   logic        conv_start, integ_win, count_win_n, flag, flag_n;
   logic [31:0] disp_data, bcd_out;

   int checks = 0, errors = 0, cyc = 0;

   // strobe pattern, expected group output for stored 32'h1357_2468
   localparam logic [39:0] VEC [NV] = '{
      {8'hFF, 32'h0000_0000}, {8'h00, 32'h1357_2468},
      {8'hFE, 32'h0000_0008}, {8'h7F, 32'h1000_0000},
      {8'hAA, 32'h0307_0408}, {8'h55, 32'h1050_2060},
      {8'hF0, 32'h0000_2468}, {8'h0F, 32'h1357_0000}};

   conv_hold_ctrl #(.CYC_PER_MS(CPM)) dut (
      .clk(clk), .rst_n(rst_n), .hold_n(hold_n), .hold_end_n(hold_end_n),
      .trig_n(trig_n), .flag_rst_n(flag_rst_n), .strobe_n(strobe_n),
      .deint_busy(deint_busy), .conv_data(conv_data), .conv_start(conv_start),
      .integ_win(integ_win), .count_win_n(count_win_n), .flag(flag),
      .flag_n(flag_n), .disp_data(disp_data), .bcd_out(bcd_out));

   always #10 clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 150000) begin
         errors = errors + 1;
         $display("FAIL watchdog all requirements actual=%0d expected=<150000 cycles", cyc);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_start(input int lim, output int w);
      w = 0;
      while (!conv_start && w < lim) begin @(negedge clk); w++; end
   endtask

   task automatic count_starts(input int n, output int c);
      c = 0;
      repeat (n) begin @(negedge clk); if (conv_start) c++; end
   endtask

   task automatic wait_rise(input int lim, output int w);
      bit p;
      w = 0;
      do begin p = flag; @(negedge clk); w++; end
      while (!(flag && !p) && w < lim);
   endtask

   task automatic pulse_trig(input int len);
      trig_n = 1'b0; tick(len); trig_n = 1'b1;
   endtask

   initial begin
      int w, k, n, rises;
      bit p, stab;
      tick(5);
      chk(!flag && flag_n && disp_data == 0 && bcd_out == 0 && !conv_start,
          "R1 reset outputs", {disp_data[29:0], flag, flag_n}, 32'h1);
      conv_data = 32'hA1B2_C3D4;
      rst_n = 1'b1;
      wait_start(20, w);
      chk(w < 20, "R1 first start after reset", w, 20);
      // R3 window placement in free-run
      k = 0; while (!integ_win) begin @(negedge clk); k++; end
      chk(k == DLY, "R3 window delay", k, DLY);
      k = 0; while (integ_win) begin @(negedge clk); k++; end
      chk(k == WIN, "R3 window width", k, WIN);
      // R4 store and flag width, data stable under flag
      wait_rise(CONV, w);
      chk(disp_data == 32'hA1B2_C3D4, "R4 stored result", disp_data, 32'hA1B2_C3D4);
      k = 0; stab = 1;
      while (flag) begin
         if (k == 10) conv_data = 32'h1357_2468;
         if (disp_data != 32'hA1B2_C3D4) stab = 0;
         k++; @(negedge clk);
      end
      chk(k == FLG, "R4 flag width", k, FLG);
      chk(stab, "R4 data stable while flag", disp_data, 32'hA1B2_C3D4);
      wait_rise(CONV, w);
      chk(disp_data == 32'h1357_2468, "R4 next store", disp_data, 32'h1357_2468);
      // R2 back-to-back period
      wait_start(CONV + 10, w);
      k = 0; do begin @(negedge clk); k++; end while (!conv_start && k < 3 * CONV);
      chk(k == CONV, "R2 conversion period", k, CONV);
      // R11 strobe table
      for (int i = 0; i < NV; i++) begin
         strobe_n = VEC[i][39:32];
         #1;
         chk(bcd_out == VEC[i][31:0], "R11 group gating", bcd_out, VEC[i][31:0]);
         chk(disp_data == 32'h1357_2468, "R11 display unaffected", disp_data, 32'h1357_2468);
         @(negedge clk);
      end
      strobe_n = 8'h00;
      // R5 immediate hold
      hold_n = 1'b0; conv_data = 32'h5555_AAAA; tick(20);
      rises = 0; n = 0; p = flag;
      repeat (4500) begin
         @(negedge clk);
         if (flag && !p) rises++;
         if (conv_start) n++;
         p = flag;
      end
      chk(disp_data == 32'h1357_2468, "R5 result frozen", disp_data, 32'h1357_2468);
      chk(rises == 0, "R5 no flag under hold", rises, 0);
      chk(n >= 2, "R5 conversions continue", n, 2);
      hold_n = 1'b1;
      wait_rise(3 * CONV, w);
      chk(disp_data == 32'h5555_AAAA, "R5 update after hold", disp_data, 32'h5555_AAAA);
      // R6 hold at end of conversion
      conv_data = 32'h0246_8ACE;
      wait_start(CONV + 10, w);
      tick(300);
      hold_end_n = 1'b0;
      wait_rise(CONV, w);
      chk(disp_data == 32'h0246_8ACE, "R6 running conversion stored", disp_data, 32'h0246_8ACE);
      count_starts(4500, n);
      chk(n == 0, "R6 no further starts", n, 0);
      // R13 glitch rejected
      conv_data = 32'h9988_7766;
      pulse_trig(2);
      count_starts(100, n);
      chk(n == 0, "R13 short trigger ignored", n, 0);
      // R7 closure edge starts nothing, release starts exactly one
      trig_n = 1'b0;
      count_starts(40, n);
      chk(n == 0, "R7 closing edge no start", n, 0);
      trig_n = 1'b1;
      wait_start(30, w);
      chk(w < 30, "R7 release starts", w, 30);
      k = 0; while (!integ_win) begin @(negedge clk); k++; end
      chk(k == DLY, "R3 triggered window delay", k, DLY);
      count_starts(6000, n);
      chk(n == 0, "R7 exactly one conversion", n, 0);
      chk(disp_data == 32'h9988_7766, "R7 triggered result", disp_data, 32'h9988_7766);
      // R8 trigger during running conversion
      pulse_trig(20);
      wait_start(30, w);
      tick(300);
      pulse_trig(20);
      count_starts(5000, n);
      chk(n == 0, "R8 trigger while busy ignored", n, 0);
      // R9 both holds closed
      hold_n = 1'b0; conv_data = 32'h1111_2222; tick(20);
      pulse_trig(20);
      wait_start(30, w);
      chk(w < 30, "R9 trigger still converts", w, 30);
      rises = 0; p = flag;
      repeat (3000) begin @(negedge clk); if (flag && !p) rises++; p = flag; end
      chk(rises == 0 && disp_data == 32'h9988_7766, "R9 immediate hold wins",
          disp_data, 32'h9988_7766);
      // R12 count window, R10 flag clear
      hold_n = 1'b1; conv_data = 32'h3141_5926; tick(20);
      pulse_trig(20);
      wait_start(30, w);
      tick(500);
      deint_busy = 1'b1; #1;
      chk(count_win_n == 1'b1, "R12 high inside integration", count_win_n, 1);
      tick(800); #1;
      chk(count_win_n == 1'b0, "R12 low in count interval", count_win_n, 0);
      deint_busy = 1'b0; #1;
      chk(count_win_n == 1'b1, "R12 high when counting done", count_win_n, 1);
      wait_rise(CONV, w);
      chk(disp_data == 32'h3141_5926, "R10 store before clear", disp_data, 32'h3141_5926);
      tick(100);
      flag_rst_n = 1'b0; tick(10);
      chk(!flag && flag_n, "R10 flag forced inactive", {flag, flag_n}, 32'h1);
      flag_rst_n = 1'b1; tick(20);
      chk(!flag && flag_n, "R10 flag stays clear", {flag, flag_n}, 32'h1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule